// File: doc/BRIEF.md
# Selectable-Source Timebase Prescaler

This block turns whichever timebase drives its clock into a one-cycle enable once per second for the timekeeping counters. The source can be a 32768 Hz watch crystal, a 1, 2 or 4 MHz crystal or external clock, or a 50 Hz or 60 Hz mains-derived line. A 3-bit source code tells the block which of these is present. The block then counts its clock modulo the matching divisor and keeps a phase count that restarts at zero at the start of every second.

From that phase count the block also derives several other outputs. There is a strobe at the middle and at the end of each second. There is a set of binary sub-second strobes for a periodic interrupt unit. There is also a multiplexed clock output, selected by a second 3-bit code. That output can be held low, carry the raw input clock, carry one of five binary divisions of the phase count, or carry a 1 Hz square wave.

Any change of the source code restarts the second from phase zero. This means the block never emits a shortened or stretched second under the old divisor. All divisors are parameters.

Top module: `tbase_prescaler`

## Requirements
- R1: While the active-low reset is asserted, the 1 Hz tick, the half-second strobe and every binary tap are 0, and the clock output is 0 when the output code is 0.
- R2: For source codes 0 = 32 kHz crystal, 1 = 1 MHz, 2 = 2 MHz, 3 = 4 MHz, 4 = 50 Hz line and 5 = 60 Hz line, the tick is high for exactly one cycle out of every D cycles. D is that source's divisor parameter. The phase count runs 0 to D-1, and the tick is high in the cycle after the phase count reached D-1.
- R3: Source codes 6 and 7 use the same divisor as code 0.
- R4: The half-second strobe is high for one cycle after the phase count reached D/2-1, and for one cycle after it reached D-1.
- R5: Binary tap k (k = 0 to TAP_N-1) is high for one cycle after a cycle in which phase bits k down to 0 were all ones.
- R6: When the sampled source code differs from the code sampled on the previous edge, that edge clears the phase count to zero and drives the tick, the half strobe, every tap and the square wave low. The first following tick comes D edges later.
- R7: Output code 0 holds the clock output low. Output code 1 passes the raw input clock through, high while the clock is high.
- R8: Output codes 2 to 6 present bit (code-2) of the current phase count on the clock output.
- R9: Output code 7 presents a square wave that toggles whenever the half strobe is high. The square wave is cleared by reset and by a source change, so it is low in the first half of each second and high in the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock from the selected source |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel_i | input | 3 | Source frequency code |
| osel_i | input | 3 | Clock output select code |
| tick_1hz_o | output | 1 | One-cycle enable once per second |
| half_o | output | 1 | One-cycle strobe at mid-second and end of second |
| tap_o | output | TAP_N | Binary sub-second strobes |
| clk_out_o | output | 1 | Multiplexed clock output |

## Verification
The bench walks every source code, including the two reserved ones. A divisor mixed up between two modes would show as a tick landing on the wrong cycle. It changes the source in the middle of a second: a design that keeps its old phase would produce a short first second, and one that does not clear its strobes would let a stale tick through the switch cycle. It steps the output code through all eight values under several phases. A wrong bit index, a square wave of the wrong polarity, or a raw clock that is not passed through while the clock is high each show up as a mismatched output level. The half strobe is checked in the line modes, where D/2 is not a power of two, so a mid-second compare built on a shift of the phase count would fire in the wrong cycle.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [2:0] {
        SRC_XTAL32 = 3'd0,
        SRC_1M     = 3'd1,
        SRC_2M     = 3'd2,
        SRC_4M     = 3'd3,
        SRC_LINE50 = 3'd4,
        SRC_LINE60 = 3'd5,
        SRC_RSV6   = 3'd6,
        SRC_RSV7   = 3'd7
    } src_e;

    typedef enum logic [2:0] {
        CO_OFF = 3'd0,
        CO_RAW = 3'd1,
        CO_B0  = 3'd2,
        CO_B1  = 3'd3,
        CO_B2  = 3'd4,
        CO_B3  = 3'd5,
        CO_B4  = 3'd6,
        CO_SQ  = 3'd7
    } co_e;

    function automatic int unsigned max_of6(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d,
                                            input int unsigned e, input int unsigned f);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        if (f > m) m = f;
        return m;
    endfunction

endpackage

// File: rtl/prs_divsel.sv
module prs_divsel #(
    parameter int unsigned DIV_XTAL32 = 32768,
    parameter int unsigned DIV_1M     = 1000000,
    parameter int unsigned DIV_2M     = 2000000,
    parameter int unsigned DIV_4M     = 4000000,
    parameter int unsigned DIV_L50    = 50,
    parameter int unsigned DIV_L60    = 60,
    parameter int unsigned CNT_W      = 22
) (
    input  logic [2:0]       fsel,
    output logic [CNT_W-1:0] last
);
    import prs_pkg::*;

    localparam logic [CNT_W-1:0] LAST_X32 = CNT_W'(DIV_XTAL32 - 1);
    localparam logic [CNT_W-1:0] LAST_1M  = CNT_W'(DIV_1M - 1);
    localparam logic [CNT_W-1:0] LAST_2M  = CNT_W'(DIV_2M - 1);
    localparam logic [CNT_W-1:0] LAST_4M  = CNT_W'(DIV_4M - 1);
    localparam logic [CNT_W-1:0] LAST_L50 = CNT_W'(DIV_L50 - 1);
    localparam logic [CNT_W-1:0] LAST_L60 = CNT_W'(DIV_L60 - 1);

    always_comb begin
        case (src_e'(fsel))
            SRC_1M:     last = LAST_1M;
            SRC_2M:     last = LAST_2M;
            SRC_4M:     last = LAST_4M;
            SRC_LINE50: last = LAST_L50;
            SRC_LINE60: last = LAST_L60;
            default:    last = LAST_X32;   // codes 0, 6, 7 (R3)
        endcase
    end

endmodule

// File: rtl/prs_phase.sv
module prs_phase #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       fsel,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] cnt_q,
    output logic             restart
);
    typedef struct packed {
        logic [2:0]       fsel;
        logic [CNT_W-1:0] cnt;
    } phase_st_t;

    phase_st_t st_d, st_q;

    assign restart = (fsel != st_q.fsel);
    assign cnt_q   = st_q.cnt;

    always_comb begin
        st_d      = st_q;
        st_d.fsel = fsel;
        if (restart || (st_q.cnt == last)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the phase either restarts at zero or steps by exactly one
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/prs_taps.sv
module prs_taps #(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned TAP_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] last,
    input  logic             restart,
    output logic             tick_q,
    output logic             half_q,
    output logic [TAP_N-1:0] tap_q,
    output logic             sq_q
);
    typedef struct packed {
        logic             tick;
        logic             half;
        logic [TAP_N-1:0] tap;
        logic             sq;
    } tap_st_t;

    tap_st_t st_d, st_q;
    logic [CNT_W-1:0] mid;
    logic             at_end;
    logic             at_mid;

    assign mid    = last >> 1;
    assign at_end = (cnt_q == last);
    assign at_mid = (cnt_q == mid);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '0;
        end else begin
            st_d.tick = at_end;
            st_d.half = at_end || at_mid;
            for (int k = 0; k < TAP_N; k++) begin
                st_d.tap[k] = ((cnt_q & CNT_W'((1 << (k + 1)) - 1)) == CNT_W'((1 << (k + 1)) - 1));
            end
            st_d.sq = (at_end || at_mid) ? ~st_q.sq : st_q.sq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_q = st_q.tick;
    assign half_q = st_q.half;
    assign tap_q  = st_q.tap;
    assign sq_q   = st_q.sq;

    // R2: a tick is a single-cycle pulse
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

    // R4: every end-of-second tick is also a half strobe
    assert_tick_has_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> half_q);

    // R9: the square wave flips exactly when the half strobe fires
    assert_sq_toggles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        half_q |-> (sq_q != $past(sq_q)));

endmodule

// File: rtl/prs_clkmux.sv
module prs_clkmux #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       osel,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             sq_q,
    output logic             clk_out
);
    import prs_pkg::*;

    logic [CNT_W+4:0] pad;
    logic [2:0]       idx;

    assign pad = {5'b0, cnt_q};
    assign idx = osel - 3'd2;

    always_comb begin
        case (co_e'(osel))
            CO_OFF:  clk_out = 1'b0;
            CO_RAW:  clk_out = clk;
            CO_SQ:   clk_out = sq_q;
            default: clk_out = pad[idx];
        endcase
    end

    // R7: disabled output stays low
    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (osel == 3'd0) |-> !clk_out);

endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
    parameter int unsigned DIV_XTAL32 = 32768,
    parameter int unsigned DIV_1M     = 1000000,
    parameter int unsigned DIV_2M     = 2000000,
    parameter int unsigned DIV_4M     = 4000000,
    parameter int unsigned DIV_L50    = 50,
    parameter int unsigned DIV_L60    = 60,
    parameter int unsigned TAP_N      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       fsel_i,
    input  logic [2:0]       osel_i,
    output logic             tick_1hz_o,
    output logic             half_o,
    output logic [TAP_N-1:0] tap_o,
    output logic             clk_out_o
);
    localparam int unsigned DIV_MAX = prs_pkg::max_of6(DIV_XTAL32, DIV_1M, DIV_2M,
                                                       DIV_4M, DIV_L50, DIV_L60);
    localparam int unsigned CNT_W   = $clog2(DIV_MAX);

    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             sq_q;

    prs_divsel #(
        .DIV_XTAL32(DIV_XTAL32), .DIV_1M(DIV_1M), .DIV_2M(DIV_2M),
        .DIV_4M(DIV_4M), .DIV_L50(DIV_L50), .DIV_L60(DIV_L60), .CNT_W(CNT_W)
    ) divsel_i (
        .fsel (fsel_i),
        .last (last)
    );

    prs_phase #(.CNT_W(CNT_W)) phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsel    (fsel_i),
        .last    (last),
        .cnt_q   (cnt_q),
        .restart (restart)
    );

    prs_taps #(.CNT_W(CNT_W), .TAP_N(TAP_N)) taps_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_q   (cnt_q),
        .last    (last),
        .restart (restart),
        .tick_q  (tick_1hz_o),
        .half_q  (half_o),
        .tap_q   (tap_o),
        .sq_q    (sq_q)
    );

    prs_clkmux #(.CNT_W(CNT_W)) clkmux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .osel    (osel_i),
        .cnt_q   (cnt_q),
        .sq_q    (sq_q),
        .clk_out (clk_out_o)
    );

    // R6: a source change silences every strobe on the following cycle
    assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_i != $past(fsel_i)) |=> (!tick_1hz_o && !half_o && (tap_o == '0)));

endmodule

// File: tb/tbase_prescaler_tb_top.sv
`timescale 1ns/1ps
module tbase_prescaler_tb_top;

    localparam int unsigned D32   = 16;
    localparam int unsigned D1M   = 10;
    localparam int unsigned D2M   = 20;
    localparam int unsigned D4M   = 40;
    localparam int unsigned D50   = 50;
    localparam int unsigned D60   = 60;
    localparam int unsigned TAPS  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      fsel = 3'd0;
    logic [2:0]      osel = 3'd0;
    logic            tick, half, cko;
    logic [TAPS-1:0] tap;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tbase_prescaler #(
        .DIV_XTAL32(D32), .DIV_1M(D1M), .DIV_2M(D2M), .DIV_4M(D4M),
        .DIV_L50(D50), .DIV_L60(D60), .TAP_N(TAPS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fsel_i(fsel), .osel_i(osel),
        .tick_1hz_o(tick), .half_o(half), .tap_o(tap), .clk_out_o(cko)
    );

    typedef struct {
        bit              tick;
        bit              half;
        bit [TAPS-1:0]   tap;
        int unsigned     cnt;
        bit              sq;
        bit              chg;
        bit [2:0]        fs;
    } exp_t;

    exp_t q[$];

    function automatic int unsigned div_of(input bit [2:0] f);
        case (f)
            3'd1: return D1M;
            3'd2: return D2M;
            3'd3: return D4M;
            3'd4: return D50;
            3'd5: return D60;
            default: return D32;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model: pushes the expected state after each edge
    int unsigned m_cnt = 0;
    bit [2:0]    m_fs  = 3'd0;
    bit          m_sq  = 1'b0;

    always @(posedge clk) begin
        if (rst_n) begin
            exp_t e;
            int unsigned d;
            d     = div_of(fsel);
            e.chg = (fsel != m_fs);
            e.fs  = fsel;
            if (e.chg) begin
                e.tick = 0; e.half = 0; e.tap = '0;
                m_sq = 0; m_cnt = 0;
            end else begin
                e.tick = (m_cnt == d - 1);
                e.half = (m_cnt == d / 2 - 1) || (m_cnt == d - 1);
                for (int k = 0; k < TAPS; k++)
                    e.tap[k] = ((m_cnt & ((1 << (k + 1)) - 1)) == ((1 << (k + 1)) - 1));
                if (e.half) m_sq = ~m_sq;
                m_cnt = (m_cnt == d - 1) ? 0 : m_cnt + 1;
            end
            e.cnt = m_cnt;
            e.sq  = m_sq;
            m_fs  = fsel;
            q.push_back(e);
        end
    end

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            string rt, rc;
            int    ec;
            e  = q.pop_front();
            rt = e.chg ? "R6" : ((e.fs >= 3'd6) ? "R3" : "R2");
            check(rt, "tick", tick, e.tick);
            check(e.chg ? "R6" : "R4", "half", half, e.half);
            check(e.chg ? "R6" : "R5", "tap", tap, e.tap);
            case (osel)
                3'd0, 3'd1: begin ec = 0; rc = "R7"; end
                3'd7:       begin ec = e.sq; rc = "R9"; end
                default:    begin ec = (e.cnt >> (osel - 2)) & 1; rc = "R8"; end
            endcase
            check(rc, "clk_out", cko, ec);
        end
    end

    task automatic run(input bit [2:0] f, input bit [2:0] o, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            fsel = f;
            osel = o;
            if (o == 3'd1) begin
                #0.5;
                check("R7", "raw clock high phase", cko, 1);
            end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "tick in reset", tick, 0);
        check("R1", "half in reset", half, 0);
        check("R1", "tap in reset", tap, 0);
        check("R1", "clk_out in reset", cko, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        // 32 kHz mode, all output codes
        for (int o = 0; o < 8; o++) run(3'd0, 3'(o), 12);
        run(3'd0, 3'd7, 40);
        // MHz modes with various output codes
        run(3'd1, 3'd2, 35);
        run(3'd2, 3'd3, 50);
        run(3'd3, 3'd7, 90);
        run(3'd3, 3'd6, 30);
        // line modes, mid-second switches (R6)
        run(3'd4, 3'd7, 23);
        run(3'd5, 3'd4, 130);
        run(3'd4, 3'd5, 110);
        run(3'd5, 3'd7, 37);
        // reserved codes (R3)
        run(3'd6, 3'd2, 40);
        run(3'd7, 3'd1, 40);
        run(3'd0, 3'd3, 7);
        run(3'd2, 3'd0, 45);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule